// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block talks to a small three-wire serial EEPROM holding 128 bytes. Coming out of reset, it reads a fixed configuration image of eleven bytes. The first byte is a signature. The remaining ten bytes fill a 48-bit station address, a 16-bit subsystem device identifier and a 16-bit subsystem vendor identifier. The image is accepted only when the signature byte matches. While the load is running, a busy output tells the host bus logic to refuse or retry target accesses.

When the load is finished, the same serial engine serves single-byte commands from the host: read, write and erase. Write and erase are always preceded by a write-enable command. Completion is detected by polling the EEPROM's data-out line, and a bounded wait raises an error flag if the device never reports ready.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While reset is held, loadBusy and cmdBusy are 1, loadDone and loadValid are 0, and eeCs and eeSk are 0.
- R2: After reset the block reads byte addresses 0 through 10 in ascending order. Each read is its own command with chip select raised. It is sent as a start bit 1, opcode bits 1,0 and the 7-bit address, most significant bit first. The EEPROM samples eeDi on each rising edge of eeSk.
- R3: If byte 0 equals A5h, loadValid becomes 1 and the outputs are loaded as follows. macAddr bits 8k+7:8k come from byte k+1 (k = 0..5). devId is {byte 8, byte 7}. venId is {byte 10, byte 9}.
- R4: If byte 0 is not A5h, loading stops after that single read. loadDone becomes 1, loadValid stays 0, and macAddr, devId and venId stay 0.
- R5: loadBusy stays 1 until loadDone rises and is 0 from then on. loadDone stays 1 until the next reset.
- R6: In a host read (cmdOp 2'b00), the block sends opcode 1,0 and the address. It then ignores the dummy 0 bit and collects 8 data bits, most significant bit first, into rdData.
- R7: A host write (cmdOp 2'b01) runs three steps. First it sends write-enable: opcode 0,0 then address bits 1,1,x,x,x,x,x. Next it sends opcode 0,1, the address and 8 data bits, most significant bit first. Finally it lowers chip select, raises it again and waits until eeDo is 1 before cmdBusy clears.
- R8: A host erase (cmdOp 2'b10 or 2'b11) sends write-enable and then opcode 1,1 with the address. Afterwards it polls for ready in the same way as a write.
- R9: If eeDo stays 0 for POLL_MAX clock cycles during polling, errFlag becomes 1 and cmdBusy clears. The next accepted command clears errFlag.
- R10: cmdValid has no effect while cmdBusy is 1. It starts no serial command and does not change rdData.
- R11: eeSk is only high while eeCs is high, and eeDi does not change while eeSk is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the autoload |
| cmdValid | input | 1 | Host command request, taken only when cmdBusy is 0 |
| cmdOp | input | 2 | 00 read, 01 write, 1x erase |
| cmdAddr | input | 7 | EEPROM byte address |
| cmdData | input | 8 | Write data |
| cmdBusy | output | 1 | A load or command is in progress; requests are refused |
| rdData | output | 8 | Byte returned by the last host read |
| errFlag | output | 1 | Last write or erase timed out waiting for ready |
| loadBusy | output | 1 | Autoload in progress; host target accesses must be held off |
| loadDone | output | 1 | Autoload finished |
| loadValid | output | 1 | Autoload found the signature |
| macAddr | output | 48 | Loaded station address |
| devId | output | 16 | Loaded subsystem device identifier |
| venId | output | 16 | Loaded subsystem vendor identifier |
| eeCs | output | 1 | EEPROM chip select |
| eeSk | output | 1 | EEPROM serial clock |
| eeDi | output | 1 | Serial data to the EEPROM |
| eeDo | input | 1 | Serial data and ready status from the EEPROM |

## Verification
The bench builds the block with DIV=2 and POLL_MAX=200. A full eleven-byte autoload then takes under a thousand cycles, so several resets fit in one run. The bench's EEPROM model normally becomes ready after 60 cycles. Stretching that to 1000 cycles drives the ready poll past its limit, which exercises the timeout path without a long run. The small divider also keeps every bit of every command frame cheap to decode and log in the model.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 8;
  localparam int FRAME_W   = 19;
  localparam int CNT_W     = 5;
  localparam int CFG_BYTES = 11;
  localparam int IDX_W     = 4;

  localparam logic [CNT_W-1:0] RD_BITS  = 5'd19;
  localparam logic [CNT_W-1:0] WR_BITS  = 5'd18;
  localparam logic [CNT_W-1:0] CMD_BITS = 5'd10;

  typedef struct packed {
    logic               go;
    logic [CNT_W-1:0]   nBits;
    logic [FRAME_W-1:0] txWord;
    logic               pollGo;
    logic               capCfg;
    logic [IDX_W-1:0]   capIdx;
    logic               capRd;
  } strobe_t;

  typedef struct packed {
    logic              frameDone;
    logic              pollOk;
    logic              pollTimeout;
    logic [DATA_W-1:0] rxByte;
  } status_t;

  function automatic logic [FRAME_W-1:0] readFrame(input logic [ADDR_W-1:0] a);
    return {1'b1, 2'b10, a, 9'b0};
  endfunction

  function automatic logic [FRAME_W-1:0] enableFrame();
    return {1'b1, 2'b00, 2'b11, 5'b0, 9'b0};
  endfunction

  function automatic logic [FRAME_W-1:0] writeFrame(input logic [ADDR_W-1:0] a,
                                                    input logic [DATA_W-1:0] d);
    return {1'b1, 2'b01, a, d, 1'b0};
  endfunction

  function automatic logic [FRAME_W-1:0] eraseFrame(input logic [ADDR_W-1:0] a);
    return {1'b1, 2'b11, a, 9'b0};
  endfunction
endpackage

// File: rtl/eecfg_dp.sv
module eecfg_dp
  import eecfg_pkg::*;
#(
  parameter int DIV      = 4,
  parameter int POLL_MAX = 20000
) (
  input  logic           clk,
  input  logic           rst,
  input  strobe_t        stb,
  output status_t        sts,
  output logic           eeCs,
  output logic           eeSk,
  output logic           eeDi,
  input  logic           eeDo,
  output logic [47:0]    macAddr,
  output logic [15:0]    devId,
  output logic [15:0]    venId,
  output logic [7:0]     rdData
);
  localparam int DIV_W  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int POLL_W = $clog2(POLL_MAX + 1);

  logic [DIV_W-1:0]   divCnt;
  logic               tick;
  logic               active, phase, polling;
  logic [CNT_W-1:0]   bitsLeft;
  logic [FRAME_W-1:0] txShift;
  logic [DATA_W-1:0]  rxShift;
  logic [POLL_W-1:0]  pollCnt;
  logic               csReg, skReg;
  logic               frameDoneR, pollOkR, pollToR;
  logic [DATA_W-1:0]  cfg [CFG_BYTES];

  assign tick = (divCnt == DIV_W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || stb.go || !active || tick) divCnt <= '0;
    else                                  divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; phase <= 1'b0; polling <= 1'b0;
      bitsLeft <= '0; txShift <= '0; rxShift <= '0; pollCnt <= '0;
      csReg <= 1'b0; skReg <= 1'b0;
      frameDoneR <= 1'b0; pollOkR <= 1'b0; pollToR <= 1'b0;
    end else begin
      frameDoneR <= 1'b0;
      pollOkR    <= 1'b0;
      pollToR    <= 1'b0;
      if (stb.go) begin
        active   <= 1'b1;
        csReg    <= 1'b1;
        skReg    <= 1'b0;
        phase    <= 1'b0;
        bitsLeft <= stb.nBits;
        txShift  <= stb.txWord;
      end else if (active && tick) begin
        if (!phase) begin
          skReg   <= 1'b1;
          phase   <= 1'b1;
          rxShift <= {rxShift[DATA_W-2:0], eeDo};
        end else begin
          skReg    <= 1'b0;
          phase    <= 1'b0;
          txShift  <= txShift << 1;
          bitsLeft <= bitsLeft - CNT_W'(1);
          if (bitsLeft == CNT_W'(1)) begin
            active     <= 1'b0;
            csReg      <= 1'b0;
            frameDoneR <= 1'b1;
          end
        end
      end
      if (stb.pollGo) begin
        polling <= 1'b1;
        csReg   <= 1'b1;
        pollCnt <= '0;
      end else if (polling) begin
        if (eeDo) begin
          polling <= 1'b0;
          csReg   <= 1'b0;
          pollOkR <= 1'b1;
        end else if (pollCnt == POLL_W'(POLL_MAX - 1)) begin
          polling <= 1'b0;
          csReg   <= 1'b0;
          pollToR <= 1'b1;
        end else begin
          pollCnt <= pollCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CFG_BYTES; i++) cfg[i] <= '0;
      rdData <= '0;
    end else begin
      if (stb.capCfg) cfg[stb.capIdx] <= rxShift;
      if (stb.capRd)  rdData <= rxShift;
    end
  end

  for (genvar k = 0; k < 6; k++) begin : g_mac
    assign macAddr[8*k +: 8] = cfg[k + 1];
  end
  assign devId = {cfg[8], cfg[7]};
  assign venId = {cfg[10], cfg[9]};

  assign eeCs = csReg;
  assign eeSk = skReg;
  assign eeDi = active & txShift[FRAME_W-1];

  assign sts.frameDone   = frameDoneR;
  assign sts.pollOk      = pollOkR;
  assign sts.pollTimeout = pollToR;
  assign sts.rxByte      = rxShift;
endmodule

// File: rtl/eecfg_ctrl.sv
module eecfg_ctrl
  import eecfg_pkg::*;
#(
  parameter logic [7:0] SIG = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  status_t           sts,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output strobe_t           stb,
  output logic              loadBusy,
  output logic              loadDone,
  output logic              loadValid,
  output logic              cmdBusy,
  output logic              errFlag
);
  typedef enum logic [2:0] {
    S_START, S_ALOAD, S_IDLE, S_HREAD, S_ENABLE, S_MODIFY, S_POLL
  } state_t;

  state_t            state, stateN;
  logic [IDX_W-1:0]  idx, idxN;
  logic [1:0]        opR, opN;
  logic [ADDR_W-1:0] addrR, addrN;
  logic [DATA_W-1:0] dataR, dataN;
  logic              doneR, doneN, validR, validN, errR, errN;

  always_comb begin
    stb    = '0;
    stateN = state;
    idxN   = idx;
    opN    = opR;
    addrN  = addrR;
    dataN  = dataR;
    doneN  = doneR;
    validN = validR;
    errN   = errR;
    unique case (state)
      S_START: begin
        stb.go     = 1'b1;
        stb.nBits  = RD_BITS;
        stb.txWord = readFrame(ADDR_W'(idx));
        stateN     = S_ALOAD;
      end
      S_ALOAD: if (sts.frameDone) begin
        if (idx == '0 && sts.rxByte != SIG) begin
          doneN  = 1'b1;
          stateN = S_IDLE;
        end else begin
          stb.capCfg = 1'b1;
          stb.capIdx = idx;
          if (idx == IDX_W'(CFG_BYTES - 1)) begin
            doneN  = 1'b1;
            validN = 1'b1;
            stateN = S_IDLE;
          end else begin
            idxN       = idx + 1'b1;
            stb.go     = 1'b1;
            stb.nBits  = RD_BITS;
            stb.txWord = readFrame(ADDR_W'(idx + 1'b1));
          end
        end
      end
      S_IDLE: if (cmdValid) begin
        opN    = cmdOp;
        addrN  = cmdAddr;
        dataN  = cmdData;
        errN   = 1'b0;
        stb.go = 1'b1;
        if (cmdOp == 2'b00) begin
          stb.nBits  = RD_BITS;
          stb.txWord = readFrame(cmdAddr);
          stateN     = S_HREAD;
        end else begin
          stb.nBits  = CMD_BITS;
          stb.txWord = enableFrame();
          stateN     = S_ENABLE;
        end
      end
      S_HREAD: if (sts.frameDone) begin
        stb.capRd = 1'b1;
        stateN    = S_IDLE;
      end
      S_ENABLE: if (sts.frameDone) begin
        stb.go = 1'b1;
        if (opR[1]) begin
          stb.nBits  = CMD_BITS;
          stb.txWord = eraseFrame(addrR);
        end else begin
          stb.nBits  = WR_BITS;
          stb.txWord = writeFrame(addrR, dataR);
        end
        stateN = S_MODIFY;
      end
      S_MODIFY: if (sts.frameDone) begin
        stb.pollGo = 1'b1;
        stateN     = S_POLL;
      end
      S_POLL: begin
        if (sts.pollOk) stateN = S_IDLE;
        else if (sts.pollTimeout) begin
          errN   = 1'b1;
          stateN = S_IDLE;
        end
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_START; idx <= '0; opR <= '0; addrR <= '0; dataR <= '0;
      doneR <= 1'b0; validR <= 1'b0; errR <= 1'b0;
    end else begin
      state <= stateN; idx <= idxN; opR <= opN; addrR <= addrN; dataR <= dataN;
      doneR <= doneN; validR <= validN; errR <= errN;
    end
  end

  assign loadBusy  = (state == S_START) || (state == S_ALOAD);
  assign cmdBusy   = (state != S_IDLE);
  assign loadDone  = doneR;
  assign loadValid = validR;
  assign errFlag   = errR;
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import eecfg_pkg::*;
#(
  parameter int         DIV      = 4,
  parameter int         POLL_MAX = 20000,
  parameter logic [7:0] SIG      = 8'hA5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic [6:0]  cmdAddr,
  input  logic [7:0]  cmdData,
  output logic        cmdBusy,
  output logic [7:0]  rdData,
  output logic        errFlag,
  output logic        loadBusy,
  output logic        loadDone,
  output logic        loadValid,
  output logic [47:0] macAddr,
  output logic [15:0] devId,
  output logic [15:0] venId,
  output logic        eeCs,
  output logic        eeSk,
  output logic        eeDi,
  input  logic        eeDo
);
  strobe_t stb;
  status_t sts;

  eecfg_ctrl #(.SIG(SIG)) u_ctrl (
    .clk(clk), .rst(rst), .sts(sts),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .stb(stb), .loadBusy(loadBusy), .loadDone(loadDone), .loadValid(loadValid),
    .cmdBusy(cmdBusy), .errFlag(errFlag)
  );

  eecfg_dp #(.DIV(DIV), .POLL_MAX(POLL_MAX)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .sts(sts),
    .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .eeDo(eeDo),
    .macAddr(macAddr), .devId(devId), .venId(venId), .rdData(rdData)
  );
endmodule

// File: rtl/eecfg_chk.sv
module eecfg_chk (
  input logic        clk,
  input logic        rst,
  input logic        loadBusy,
  input logic        loadDone,
  input logic        loadValid,
  input logic        cmdBusy,
  input logic        errFlag,
  input logic        eeCs,
  input logic        eeSk,
  input logic        eeDi,
  input logic [47:0] macAddr,
  input logic [15:0] devId,
  input logic [15:0] venId
);
  // R5
  busy_until_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(loadBusy) |-> loadDone);
  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    loadDone |=> loadDone);
  // R5
  host_held_off_chk: assert property (@(posedge clk) disable iff (rst)
    loadBusy |-> cmdBusy);
  // R4
  no_sig_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    (loadDone && !loadValid) |-> (macAddr == '0 && devId == '0 && venId == '0));
  // R11
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    eeSk |-> eeCs);
  // R11
  di_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (eeSk && $past(eeSk)) |-> $stable(eeDi));
  // R9
  err_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(errFlag) |-> !cmdBusy);
endmodule

bind eeprom_cfg_loader eecfg_chk u_chk (
  .clk(clk), .rst(rst), .loadBusy(loadBusy), .loadDone(loadDone),
  .loadValid(loadValid), .cmdBusy(cmdBusy), .errFlag(errFlag),
  .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi),
  .macAddr(macAddr), .devId(devId), .venId(venId)
);

// File: tb/tb_eeprom_cfg_loader.sv
module tb_eeprom_cfg_loader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [6:0] cmdAddr = '0;
  logic [7:0] cmdData = '0;
  logic cmdBusy, errFlag, loadBusy, loadDone, loadValid;
  logic [7:0] rdData;
  logic [47:0] macAddr;
  logic [15:0] devId, venId;
  logic eeCs, eeSk, eeDi, eeDo;

  always #2.5 clk = ~clk;

  eeprom_cfg_loader #(.DIV(2), .POLL_MAX(200)) dut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .cmdBusy(cmdBusy), .rdData(rdData), .errFlag(errFlag),
    .loadBusy(loadBusy), .loadDone(loadDone), .loadValid(loadValid),
    .macAddr(macAddr), .devId(devId), .venId(venId),
    .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .eeDo(eeDo)
  );

  int checks = 0;
  int failures = 0;
  longint cycle = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural EEPROM model ----------------
  localparam int K_READ = 1, K_WEN = 2, K_WRITE = 3, K_ERASE = 4, K_BAD = 5;
  logic [7:0] mem [128];
  logic [23:0] logQ [$];
  int busyCycles = 60;
  longint readyAt = 0;
  int bitCnt = 0;
  int mode = 0;
  int rdPos = 0;
  int wCnt = 0;
  int kind = 0;
  logic [9:0] hdr = '0;
  logic [6:0] cAddr = '0;
  logic [7:0] wData = '0;
  logic rdBit = 1'b0;
  logic rdActive = 1'b0;
  logic ewen = 1'b0;

  assign eeDo = rdActive ? rdBit : (eeCs && (cycle >= readyAt));

  always @(posedge clk) cycle <= cycle + 1;

  always @(posedge eeSk or negedge eeCs) begin
    if (!eeCs) begin
      if (bitCnt >= 10) begin
        logQ.push_back({8'(kind), 1'b0, cAddr, (kind == K_WRITE) ? wData : 8'h00});
        if (kind == K_WRITE && ewen && wCnt >= 8) begin
          mem[cAddr] = wData; readyAt = cycle + busyCycles;
        end else if (kind == K_ERASE && ewen) begin
          mem[cAddr] = 8'hFF; readyAt = cycle + busyCycles;
        end
      end
      bitCnt = 0; mode = 0; rdActive = 1'b0; wCnt = 0;
    end else if (mode == 1) begin
      if (rdPos < 8) rdBit = mem[cAddr][7 - rdPos];
      rdPos++;
    end else if (mode == 2) begin
      wData = {wData[6:0], eeDi};
      wCnt++;
    end else begin
      hdr = {hdr[8:0], eeDi};
      bitCnt++;
      if (bitCnt == 10) begin
        cAddr = hdr[6:0];
        if (!hdr[9]) kind = K_BAD;
        else case (hdr[8:7])
          2'b10: begin kind = K_READ; mode = 1; rdActive = 1'b1; rdBit = 1'b0; rdPos = 0; end
          2'b00: begin kind = (hdr[6:5] == 2'b11) ? K_WEN : K_BAD; if (kind == K_WEN) ewen = 1'b1; end
          2'b01: begin kind = K_WRITE; mode = 2; end
          default: kind = K_ERASE;
        endcase
      end
    end
  end

  // ---------------- per-clock comparison ----------------
  logic [47:0] expMac = '0;
  logic [15:0] expDev = '0, expVen = '0;
  bit expValid = 0;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (loadDone) begin
        check(macAddr == expMac, "R3 macAddr", 64'(macAddr), 64'(expMac));
        check({devId, venId} == {expDev, expVen}, "R3 ids", 64'({devId, venId}), 64'({expDev, expVen}));
        check(loadValid == expValid, "R3/R4 loadValid", 64'(loadValid), 64'(expValid));
      end
      check(loadBusy == !loadDone, "R5 busy vs done", 64'(loadBusy), 64'(!loadDone));
      check(!(eeSk && !eeCs), "R11 sk without cs", 64'(eeSk), 64'(0));
    end
  end

  // ---------------- watchdog ----------------
  always @(negedge clk) begin
    if (cycle > 150000 && !finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycle);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic expectLog(input int k, input int a, input int d, input string tag);
    logic [23:0] e;
    logic [23:0] want;
    want = {8'(k), 8'(a), 8'(d)};
    if (logQ.size() == 0) check(0, {tag, " missing command"}, 64'(0), 64'(want));
    else begin
      e = logQ.pop_front();
      check(e == want, tag, 64'(e), 64'(want));
    end
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20000 && (cmdBusy || loadBusy); i++) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input logic [6:0] a, input logic [7:0] d);
    waitIdle();
    cmdOp = op; cmdAddr = a; cmdData = d; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
    waitIdle();
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(loadBusy && cmdBusy, "R1 busy in reset", 64'({loadBusy, cmdBusy}), 64'(3));
    check(!loadDone && !loadValid, "R1 done/valid in reset", 64'({loadDone, loadValid}), 64'(0));
    check(!eeCs && !eeSk, "R1 serial idle in reset", 64'({eeCs, eeSk}), 64'(0));
    rst = 1'b0;
    waitIdle();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37 + 11) & 8'hFF);
    mem[0] = 8'hA5;
    for (int i = 1; i <= 10; i++) mem[i] = 8'(8'h10 * i + i);
    expMac = {mem[6], mem[5], mem[4], mem[3], mem[2], mem[1]};
    expDev = {mem[8], mem[7]};
    expVen = {mem[10], mem[9]};
    expValid = 1;
    repeat (2) @(negedge clk);
    doReset();

    // R2 autoload reads 0..10 in order; R5 completion
    for (int i = 0; i <= 10; i++) expectLog(K_READ, i, 0, "R2 autoload read");
    check(logQ.size() == 0, "R2 extra commands", 64'(logQ.size()), 64'(0));
    check(loadDone && loadValid, "R3 load valid", 64'({loadDone, loadValid}), 64'(3));

    // R6 host reads
    issue(2'b00, 7'd20, 8'h00);
    expectLog(K_READ, 20, 0, "R6 read frame");
    check(rdData == mem[20], "R6 read data", 64'(rdData), 64'(mem[20]));
    issue(2'b00, 7'd127, 8'h00);
    expectLog(K_READ, 127, 0, "R6 read top address");
    check(rdData == mem[127], "R6 read top data", 64'(rdData), 64'(mem[127]));

    // R10 request while busy is ignored
    waitIdle();
    cmdOp = 2'b00; cmdAddr = 7'd5; cmdValid = 1'b1;
    @(negedge clk);
    cmdAddr = 7'd6;
    @(negedge clk);
    cmdValid = 1'b0;
    waitIdle();
    expectLog(K_READ, 5, 0, "R10 first read");
    check(logQ.size() == 0, "R10 busy request started command", 64'(logQ.size()), 64'(0));
    check(rdData == mem[5], "R10 rdData", 64'(rdData), 64'(mem[5]));

    // R7 write
    issue(2'b01, 7'd33, 8'h5A);
    expectLog(K_WEN, 7'h60, 0, "R7 write enable");
    expectLog(K_WRITE, 33, 8'h5A, "R7 write frame");
    check(mem[33] == 8'h5A, "R7 stored", 64'(mem[33]), 64'h5A);
    check(!errFlag, "R7 no error", 64'(errFlag), 64'(0));
    check(cycle >= readyAt, "R7 waited for ready", 64'(cycle), 64'(readyAt));
    issue(2'b00, 7'd33, 8'h00);
    expectLog(K_READ, 33, 0, "R7 readback frame");
    check(rdData == 8'h5A, "R7 readback", 64'(rdData), 64'h5A);

    // R8 erase
    issue(2'b10, 7'd33, 8'h00);
    expectLog(K_WEN, 7'h60, 0, "R8 write enable");
    expectLog(K_ERASE, 33, 0, "R8 erase frame");
    issue(2'b00, 7'd33, 8'h00);
    expectLog(K_READ, 33, 0, "R8 readback frame");
    check(rdData == 8'hFF, "R8 erased", 64'(rdData), 64'hFF);

    // R9 timeout then clear
    busyCycles = 1000;
    issue(2'b01, 7'd40, 8'hC3);
    expectLog(K_WEN, 7'h60, 0, "R9 write enable");
    expectLog(K_WRITE, 40, 8'hC3, "R9 write frame");
    check(errFlag, "R9 timeout flag", 64'(errFlag), 64'(1));
    repeat (1100) @(negedge clk);
    busyCycles = 60;
    issue(2'b00, 7'd40, 8'h00);
    expectLog(K_READ, 40, 0, "R9 read after timeout");
    check(!errFlag, "R9 flag cleared", 64'(errFlag), 64'(0));
    check(rdData == 8'hC3, "R9 data", 64'(rdData), 64'hC3);

    // R4 missing signature
    mem[0] = 8'h3C;
    expMac = '0; expDev = '0; expVen = '0; expValid = 0;
    logQ.delete();
    doReset();
    expectLog(K_READ, 0, 0, "R4 signature read");
    check(logQ.size() == 0, "R4 stopped after byte 0", 64'(logQ.size()), 64'(0));
    check(loadDone && !loadValid, "R4 done not valid", 64'({loadDone, loadValid}), 64'(2));
    check(macAddr == '0 && devId == '0 && venId == '0, "R4 outputs zero",
          64'(macAddr), 64'(0));

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule